// File: doc/BRIEF.md
# Programmable-Priority Interrupt Resolver

This block decides which pending interrupt an 8-bit-class CPU services next and supplies the 16-bit vector address of that source. It takes fifteen maskable request lines, three nonmaskable lines (an external pin interrupt, an illegal-opcode trap and a software trap), a 4-bit promotion field and a service strobe. The CPU raises the strobe at an instruction boundary. The block also owns the global maskable-interrupt bit I and the pin-interrupt mask bit X. It updates both bits when a source is acknowledged, and accepts software writes to them.

The maskable sources follow a fixed order. The promotion field can lift any one of them to the top, and the rest keep their relative order. The nonmaskable lines always rank above the maskable ones. The winner is registered on the strobe edge and stays on the outputs until the next strobe.

Top module: `irq_resolver`

## Requirements
- R1: While reset is low, and on the first edge after it, `win_valid` is 0, `win_id` and `win_vec` are 0, and both `i_mask` and `x_mask` are 1.
- R2: With no promotion, the maskable sources rank by index, with 0 the highest: 0 IRQ, 1 real-time, 2 IC1, 3 IC2, 4 IC3, 5 OC1, 6 OC2, 7 OC3, 8 OC4, 9 IC4/OC5, 10 timer overflow, 11 pulse-accumulator overflow, 12 pulse-accumulator edge, 13 SPI, 14 SCI. The pending unmasked source with the lowest index wins, and `win_id` reports that index.
- R3: A `prom_sel` value from 0 to 14 makes that maskable index the highest maskable priority, and the others keep their relative order. A value of 15 leaves the fixed order in force.
- R4: A promoted source is still blocked while `i_mask` is 1, and promotion does not change any source's vector.
- R5: The nonmaskable sources rank pin (id 15) first, then illegal opcode (id 16), then software trap (id 17). All three rank above every maskable source.
- R6: Maskable requests are recognized only while `i_mask` is 0. The pin request is recognized only while `x_mask` is 0. The illegal-opcode and software traps are never masked.
- R7: The vector for maskable index k is 0xFFF2 − 2k, which runs from 0xFFF2 for IRQ down to 0xFFD6 for SCI. The pin vector is 0xFFF4, the software trap 0xFFF6 and the illegal opcode 0xFFF8.
- R8: A cycle with `mask_wr` high loads `mask_wr_i` into `i_mask`. If `mask_wr_x` is 0, the same cycle clears `x_mask`. If `mask_wr_x` is 1, that value has no effect on `x_mask`.
- R9: When a strobe selects a maskable source, the illegal-opcode trap or the software trap, `i_mask` becomes 1 and `x_mask` is unchanged. When it selects the pin source, both become 1. These updates take precedence over a software write in the same cycle.
- R10: Priority is evaluated only on an edge where `svc` is 1, using the mask values held before that edge. The outputs hold steady otherwise. A strobe that finds nothing recognizable sets `win_valid` to 0 and both `win_id` and `win_vec` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 15 | Maskable requests, bit k = maskable index k |
| pin_req | input | 1 | External pin interrupt request |
| illop_req | input | 1 | Illegal-opcode trap request |
| swi_req | input | 1 | Software trap request |
| prom_sel | input | 4 | Index of the maskable source to promote, 15 = none |
| mask_wr | input | 1 | Software write strobe for the mask bits |
| mask_wr_i | input | 1 | Value written to I |
| mask_wr_x | input | 1 | Value written to X (only 0 takes effect) |
| svc | input | 1 | Service strobe at an instruction boundary |
| win_valid | output | 1 | A recognizable source was selected by the last strobe |
| win_id | output | 5 | Selected source id |
| win_vec | output | 16 | Vector address of the selected source |
| i_mask | output | 1 | Global maskable-interrupt mask |
| x_mask | output | 1 | Pin-interrupt mask |

## Verification
Every result appears on the outputs one clock edge after the stimulus that causes it. The winner, the vector and the mask updates from a strobe are all visible after the edge that samples `svc`. A mask write is likewise visible after the edge that samples `mask_wr`. The bench changes inputs on the falling edge and updates its reference model on the rising edge. It compares all five outputs on the following falling edge, so every comparison falls exactly one edge after its cause. Cycles without a strobe are compared as well, and this checks that the outputs hold.

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int          NM   = 15,
  parameter logic [15:0] VTOP = 16'hFFF2,
  parameter logic [15:0] VPIN = 16'hFFF4,
  parameter logic [15:0] VSWI = 16'hFFF6,
  parameter logic [15:0] VILL = 16'hFFF8,
  localparam int SW = $clog2(NM + 1),
  localparam int IW = $clog2(NM + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] irq_req,
  input  logic          pin_req,
  input  logic          illop_req,
  input  logic          swi_req,
  input  logic [SW-1:0] prom_sel,
  input  logic          mask_wr,
  input  logic          mask_wr_i,
  input  logic          mask_wr_x,
  input  logic          svc,
  output logic          win_valid,
  output logic [IW-1:0] win_id,
  output logic [15:0]   win_vec,
  output logic          i_mask,
  output logic          x_mask
);

  localparam logic [IW-1:0] ID_PIN = IW'(NM);
  localparam logic [IW-1:0] ID_ILL = IW'(NM + 1);
  localparam logic [IW-1:0] ID_SWI = IW'(NM + 2);

  logic [NM-1:0] act, promo_oh;
  logic [IW-1:0] fix_id, pro_id, m_id, nx_id;
  logic          prom_hit, pin_ok, nx_found;
  logic [15:0]   nx_vec;

  assign act = irq_req & {NM{~i_mask}};

  for (genvar g = 0; g < NM; g++) begin : g_promo
    assign promo_oh[g] = (prom_sel == SW'(g));
  end

  assign prom_hit = |(promo_oh & act);

  always_comb begin
    fix_id = '0;
    for (int k = NM - 1; k >= 0; k--)
      if (act[k]) fix_id = IW'(k);
  end

  always_comb begin
    pro_id = '0;
    for (int k = 0; k < NM; k++)
      if (promo_oh[k]) pro_id = IW'(k);
  end

  assign m_id   = prom_hit ? pro_id : fix_id;
  assign pin_ok = pin_req & ~x_mask;

  always_comb begin
    nx_found = 1'b1;
    if (pin_ok)         nx_id = ID_PIN;
    else if (illop_req) nx_id = ID_ILL;
    else if (swi_req)   nx_id = ID_SWI;
    else if (|act)      nx_id = m_id;
    else begin
      nx_id    = '0;
      nx_found = 1'b0;
    end
  end

  always_comb begin
    if (!nx_found)            nx_vec = '0;
    else if (nx_id == ID_PIN) nx_vec = VPIN;
    else if (nx_id == ID_ILL) nx_vec = VILL;
    else if (nx_id == ID_SWI) nx_vec = VSWI;
    else                      nx_vec = VTOP - (16'(nx_id) << 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_id    <= '0;
      win_vec   <= '0;
      i_mask    <= 1'b1;
      x_mask    <= 1'b1;
    end else begin
      if (mask_wr) begin
        i_mask <= mask_wr_i;
        if (!mask_wr_x) x_mask <= 1'b0;
      end
      if (svc) begin
        win_valid <= nx_found;
        win_id    <= nx_id;
        win_vec   <= nx_vec;
        if (nx_found) begin
          i_mask <= 1'b1;
          if (nx_id == ID_PIN) x_mask <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int NM = 15,
  localparam int SW = $clog2(NM + 1),
  localparam int IW = $clog2(NM + 3)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] irq_req,
  input logic          pin_req,
  input logic          illop_req,
  input logic          swi_req,
  input logic [SW-1:0] prom_sel,
  input logic          mask_wr,
  input logic          mask_wr_i,
  input logic          mask_wr_x,
  input logic          svc,
  input logic          win_valid,
  input logic [IW-1:0] win_id,
  input logic [15:0]   win_vec,
  input logic          i_mask,
  input logic          x_mask
);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !svc |=> ($stable(win_valid) && $stable(win_id) && $stable(win_vec)));

  assert_pin_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (svc && pin_req && !x_mask) |=> (win_valid && win_id == IW'(NM)));

  assert_trap_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (svc && (illop_req || swi_req)) |=> win_valid);

  assert_masked_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (svc && i_mask && !(pin_req && !x_mask) && !illop_req && !swi_req) |=> !win_valid);

  assert_x_rise_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(x_mask) |-> (win_valid && win_id == IW'(NM)));

  assert_i_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> (!win_valid || i_mask));

  assert_vec_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_vec[0] == 1'b0 && win_vec >= 16'hFFD6));

  assert_id_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_id < IW'(NM + 3)));

endmodule

bind irq_resolver irq_resolver_chk #(.NM(NM)) u_chk (.*);

// File: tb/test_irq_resolver.sv
module test_irq_resolver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] irq_req;
  logic        pin_req, illop_req, swi_req;
  logic [3:0]  prom_sel;
  logic        mask_wr, mask_wr_i, mask_wr_x, svc;
  logic        win_valid;
  logic [4:0]  win_id;
  logic [15:0] win_vec;
  logic        i_mask, x_mask;

  always #4 clk = ~clk;

  irq_resolver i_irq_resolver (.*);

  int    checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  bit          m_valid, m_i, m_x;
  int          m_id;
  logic [15:0] m_vec;

  function automatic logic [15:0] vec_of(int id);
    if (id == 15) return 16'hFFF4;
    if (id == 16) return 16'hFFF8;
    if (id == 17) return 16'hFFF6;
    return 16'(32'hFFF2 - 2 * id);
  endfunction

  task automatic pick(output bit found, output int id);
    int ord[$];
    found = 0; id = 0;
    if (pin_req && !m_x) begin found = 1; id = 15; return; end
    if (illop_req)       begin found = 1; id = 16; return; end
    if (swi_req)         begin found = 1; id = 17; return; end
    if (m_i) return;
    if (prom_sel < 15) ord.push_back(int'(prom_sel));
    for (int k = 0; k < 15; k++) if (k != int'(prom_sel)) ord.push_back(k);
    foreach (ord[n]) if (irq_req[ord[n]]) begin found = 1; id = ord[n]; return; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_valid = 0; m_id = 0; m_vec = 0; m_i = 1; m_x = 1;
    end else begin
      bit f; int id; bit ni, nx;
      pick(f, id);
      ni = m_i; nx = m_x;
      if (mask_wr) begin
        ni = mask_wr_i;
        if (!mask_wr_x) nx = 0;
      end
      if (svc) begin
        m_valid = f;
        m_id    = f ? id : 0;
        m_vec   = f ? vec_of(id) : 16'h0;
        if (f) begin
          ni = 1;
          if (id == 15) nx = 1;
        end
      end
      m_i = ni; m_x = nx;
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired (%s): got %0d cycles, expected fewer", cur_req, cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic compare();
    checks++;
    if (win_valid !== m_valid || win_id !== 5'(m_id) || win_vec !== m_vec ||
        i_mask !== m_i || x_mask !== m_x) begin
      fails++;
      $display("FAIL %s: got v=%0b id=%0d vec=%h I=%0b X=%0b, expected v=%0b id=%0d vec=%h I=%0b X=%0b",
               cur_req, win_valid, win_id, win_vec, i_mask, x_mask,
               m_valid, m_id, m_vec, m_i, m_x);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic strobe();
    svc = 1; step(); svc = 0; step();
  endtask

  task automatic write_masks(input bit iv, input bit xv);
    mask_wr = 1; mask_wr_i = iv; mask_wr_x = xv; step(); mask_wr = 0;
  endtask

  task automatic clear_reqs();
    irq_req = '0; pin_req = 0; illop_req = 0; swi_req = 0;
  endtask

  initial begin
    rst_n = 0; clear_reqs(); prom_sel = 4'd15;
    mask_wr = 0; mask_wr_i = 0; mask_wr_x = 0; svc = 0;
    @(negedge clk);
    repeat (3) step();
    rst_n = 1;
    cur_req = "R1"; step(); step();

    cur_req = "R6"; irq_req = 15'h7FFF; strobe();
    cur_req = "R8"; write_masks(0, 1); step();
    cur_req = "R8"; write_masks(1, 0); step();
    cur_req = "R8"; write_masks(0, 1); step();

    cur_req = "R2";
    for (int k = 14; k >= 0; k--) begin
      irq_req = 15'h4000 | (15'(1) << k);
      strobe();
      write_masks(0, 1);
    end
    irq_req = 15'b101_0000_0010_0000; strobe(); write_masks(0, 1);

    cur_req = "R3";
    for (int p = 0; p < 16; p++) begin
      prom_sel = 4'(p);
      irq_req = 15'h7FFF; strobe(); write_masks(0, 1);
      irq_req = 15'h0C02; strobe(); write_masks(0, 1);
    end

    cur_req = "R4";
    prom_sel = 4'd9; irq_req = 15'h0200; write_masks(1, 1); strobe();
    write_masks(0, 1); strobe(); prom_sel = 4'd15;

    cur_req = "R5";
    irq_req = 15'h7FFF; swi_req = 1; strobe(); write_masks(0, 1);
    illop_req = 1; strobe(); write_masks(0, 1);
    pin_req = 1; strobe();
    cur_req = "R9"; write_masks(0, 0); strobe();
    cur_req = "R6"; strobe();
    clear_reqs();

    cur_req = "R7";
    pin_req = 1; write_masks(0, 0); strobe(); pin_req = 0;
    swi_req = 1; strobe(); swi_req = 0;
    illop_req = 1; strobe(); illop_req = 0;

    cur_req = "R9";
    write_masks(0, 0);
    irq_req = 15'h0004; mask_wr = 1; mask_wr_i = 0; mask_wr_x = 0; svc = 1; step();
    mask_wr = 0; svc = 0; step();
    pin_req = 1; write_masks(0, 0);
    mask_wr = 1; mask_wr_i = 0; mask_wr_x = 1; svc = 1; step();
    mask_wr = 0; svc = 0; step();
    clear_reqs();

    cur_req = "R10";
    write_masks(0, 0); strobe();
    irq_req = 15'h0010; repeat (4) step();
    strobe(); irq_req = '0; repeat (3) step();

    cur_req = "R10";
    for (int n = 0; n < 600; n++) begin
      irq_req   = 15'($urandom);
      pin_req   = ($urandom % 5) == 0;
      illop_req = ($urandom % 9) == 0;
      swi_req   = ($urandom % 9) == 0;
      prom_sel  = 4'($urandom);
      mask_wr   = ($urandom % 3) == 0;
      mask_wr_i = ($urandom % 2) == 0;
      mask_wr_x = ($urandom % 2) == 0;
      svc       = ($urandom % 2) == 0;
      step();
    end
    clear_reqs(); svc = 0; mask_wr = 0; step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule